// File: doc/BRIEF.md
# Dual-Channel IDE Register Front End

This block sits between a host I/O bus and the two IDE strobe generators of a local-bus disk controller. It watches each I/O access and decides whether the access addresses the controller's own four-byte register window or the task-file window of one of the two IDE channels. A strap picks the register window's base port, either 30h or B0h. The registers are a primary timing byte, a read-only configuration byte, a secondary timing byte and a control byte.

The configuration byte reports the strap inputs and a controller identification nibble. Control writes always have a fixed group of bits forced high. The low control bit chooses the channel arrangement. With it set, only the primary channel at 1F0h answers. With it clear, the secondary channel at 170h answers as well.

The timing bytes and the control byte drive the strobe generators directly. The channel decode gives a one-hot channel select and the task-file register index for each claimed access.

Top module: `ide_regfront`

## Requirements
- R1: The register window is the four ports starting at 30h when strapAltBase is 0, and at B0h when it is 1. Accesses to the other candidate window neither read nor write any register.
- R2: A read of any address outside the register window returns FFh on ioRdData.
- R3: A read at window offset 1 returns the configuration byte. Bits 7:4 hold 1010b when strapAltId is 0 and 0101b when it is 1. Bit 0 is strapPriBase, bit 1 is strapAltBase, bit 2 is strapSlowBus and bit 3 is strapDisabled.
- R4: A write at offset 0 loads the primary timing byte and a write at offset 2 loads the secondary timing byte. Each takes effect on the clock edge that samples the write, and each reads back at its own offset.
- R5: A write at offset 1 changes no register.
- R6: A write at offset 3 stores the written byte with bits 6, 4, 3 and 2 forced to 1. Bits 7, 5, 1 and 0 are stored as written. The stored byte reads back at offset 3 and appears on ctrlValue.
- R7: While rstN is low, and after it rises until the first write, both timing bytes are 00h and the control byte is 5Fh.
- R8: When control bit 0 is 1, an access to 1F0h–1F7h gives chanSel = 01b, and 170h–177h is not claimed (chanSel = 00b).
- R9: When control bit 0 is 0, an access to 170h–177h gives chanSel = 10b, and 1F0h–1F7h still gives chanSel = 01b.
- R10: hdOnly equals control bit 1 and nonAtapi equals control bit 7.
- R11: chanSel has at most one bit set, and it is 00b whenever neither ioRdEn nor ioWrEn is high.
- R12: For a claimed task-file access, tfReg equals ioAddr[2:0]. Addresses just outside an eight-port channel window (1F8h, 16Fh) are not claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strapPriBase | input | 1 | Strap reported as configuration bit 0 |
| strapAltBase | input | 1 | Register window base: 0 = 30h, 1 = B0h |
| strapSlowBus | input | 1 | Strap reported as configuration bit 2 (bus at 33 MHz or below) |
| strapDisabled | input | 1 | Strap reported as configuration bit 3 |
| strapAltId | input | 1 | Selects the alternate identification nibble |
| ioAddr | input | 10 | I/O port address |
| ioRdEn | input | 1 | I/O read strobe |
| ioWrEn | input | 1 | I/O write strobe |
| ioWrData | input | 8 | Write data |
| ioRdData | output | 8 | Read data (combinational) |
| priTiming | output | 8 | Primary channel timing byte |
| secTiming | output | 8 | Secondary channel timing byte |
| ctrlValue | output | 8 | Stored control byte |
| hdOnly | output | 1 | Hard-drive-only mode (control bit 1) |
| nonAtapi | output | 1 | Non-ATAPI operation (control bit 7) |
| chanSel | output | 2 | One-hot task-file channel select: bit 0 primary, bit 1 secondary |
| tfReg | output | 3 | Task-file register index of the claimed access |

## Verification
The secondary channel's claim is the hardest state to reach. It needs a control write that clears bit 0, and that bit lies right next to the bits the write forces high. The stimulus first shows that 170h goes unclaimed after reset. It then writes 00h to the control offset, reads back 5Ch, and only then probes 170h–177h together with the window edges at 1F8h and 16Fh. The alternate base and the alternate identification nibble are reached by changing the straps between vectors. The bench then checks that the old window has gone dead.

// File: rtl/ide_fe_pkg.sv
package ide_fe_pkg;

  localparam int OFF_W = 2;

  localparam logic [OFF_W-1:0] OFF_PRI  = 2'd0;
  localparam logic [OFF_W-1:0] OFF_CFG  = 2'd1;
  localparam logic [OFF_W-1:0] OFF_SEC  = 2'd2;
  localparam logic [OFF_W-1:0] OFF_CTRL = 2'd3;

  typedef enum logic [2:0] {
    RD_NONE = 3'd0,
    RD_PRI  = 3'd1,
    RD_CFG  = 3'd2,
    RD_SEC  = 3'd3,
    RD_CTRL = 3'd4
  } rdSel_t;

  typedef struct packed {
    logic   wrPri;
    logic   wrSec;
    logic   wrCtrl;
    rdSel_t rdSel;
  } feStrobes_t;

endpackage

// File: rtl/ide_fe_decode.sv
module ide_fe_decode
  import ide_fe_pkg::*;
#(
  parameter int          ADDR_W   = 10,
  parameter int          TF_PORTS = 8,
  parameter logic [9:0]  BASE_LO  = 10'h030,
  parameter logic [9:0]  BASE_HI  = 10'h0B0,
  parameter logic [9:0]  PRI_TF   = 10'h1F0,
  parameter logic [9:0]  SEC_TF   = 10'h170,
  localparam int         TF_W     = $clog2(TF_PORTS),
  localparam int         N_CHAN   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRdEn,
  input  logic              ioWrEn,
  input  logic              strapAltBase,
  input  logic              secDisabled,
  output feStrobes_t        strb,
  output logic [N_CHAN-1:0] chanSel,
  output logic [TF_W-1:0]   tfReg
);

  function automatic logic [ADDR_W-1:0] chanBase(input int idx);
    return (idx == 0) ? ADDR_W'(PRI_TF) : ADDR_W'(SEC_TF);
  endfunction

  logic              access;
  logic [ADDR_W-1:0] chipBase;
  logic              chipHit;
  logic [OFF_W-1:0]  offset;

  assign access   = ioRdEn | ioWrEn;
  assign chipBase = strapAltBase ? ADDR_W'(BASE_HI) : ADDR_W'(BASE_LO);
  assign chipHit  = ioAddr[ADDR_W-1:OFF_W] == chipBase[ADDR_W-1:OFF_W];
  assign offset   = ioAddr[OFF_W-1:0];

  always_comb begin
    strb = '{wrPri: 1'b0, wrSec: 1'b0, wrCtrl: 1'b0, rdSel: RD_NONE};
    if (chipHit) begin
      if (ioWrEn) begin
        strb.wrPri  = offset == OFF_PRI;
        strb.wrSec  = offset == OFF_SEC;
        strb.wrCtrl = offset == OFF_CTRL;
      end
      unique case (offset)
        OFF_PRI:  strb.rdSel = RD_PRI;
        OFF_CFG:  strb.rdSel = RD_CFG;
        OFF_SEC:  strb.rdSel = RD_SEC;
        default:  strb.rdSel = RD_CTRL;
      endcase
    end
  end

  for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
    logic winHit;
    logic chanOn;
    assign winHit     = ioAddr[ADDR_W-1:TF_W] == chanBase(g)[ADDR_W-1:TF_W];
    assign chanOn     = (g == 0) ? 1'b1 : ~secDisabled;
    assign chanSel[g] = access & winHit & chanOn;
  end

  assign tfReg = ioAddr[TF_W-1:0];

  // R11: never more than one channel claims an access
  a_r11_chan_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanSel));

  // R11: no claim without an access strobe
  a_r11_idle_no_claim: assert property (@(posedge clk) disable iff (!rstN)
    !(ioRdEn || ioWrEn) |-> chanSel == '0);

  // R8: the secondary channel is silent while it is disabled by control
  a_r8_sec_gated: assert property (@(posedge clk) disable iff (!rstN)
    secDisabled |-> !chanSel[1]);

  // R5: the configuration offset never produces a write strobe
  a_r5_cfg_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RD_CFG) |-> !(strb.wrPri || strb.wrSec || strb.wrCtrl));

endmodule

// File: rtl/ide_fe_regs.sv
module ide_fe_regs
  import ide_fe_pkg::*;
#(
  parameter logic [3:0] ID_MAIN    = 4'b1010,
  parameter logic [3:0] ID_ALT     = 4'b0101,
  parameter logic [7:0] FORCE_MASK = 8'h5F,
  parameter logic [7:0] MODE_MASK  = 8'h03,
  localparam int        DATA_W     = 8,
  localparam logic [DATA_W-1:0] FORCE_EFF = FORCE_MASK & ~MODE_MASK
) (
  input  logic              clk,
  input  logic              rstN,
  input  feStrobes_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              strapPriBase,
  input  logic              strapAltBase,
  input  logic              strapSlowBus,
  input  logic              strapDisabled,
  input  logic              strapAltId,
  output logic [DATA_W-1:0] priTim,
  output logic [DATA_W-1:0] secTim,
  output logic [DATA_W-1:0] ctrlReg,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] cfgByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      priTim  <= '0;
      secTim  <= '0;
      ctrlReg <= FORCE_MASK;
    end else begin
      if (strb.wrPri)  priTim  <= wrData;
      if (strb.wrSec)  secTim  <= wrData;
      if (strb.wrCtrl) ctrlReg <= wrData | FORCE_EFF;
    end
  end

  assign cfgByte = {strapAltId ? ID_ALT : ID_MAIN,
                    strapDisabled, strapSlowBus, strapAltBase, strapPriBase};

  always_comb begin
    unique case (strb.rdSel)
      RD_PRI:  rdData = priTim;
      RD_CFG:  rdData = cfgByte;
      RD_SEC:  rdData = secTim;
      RD_CTRL: rdData = ctrlReg;
      default: rdData = '1;
    endcase
  end

  // R4: timing bytes only move on their own write strobe
  a_r4_pri_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrPri |=> $stable(priTim));
  a_r4_sec_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrSec |=> $stable(secTim));

  // R6: forced bits present after every control write
  a_r6_forced_bits: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCtrl |=> (ctrlReg & FORCE_EFF) == FORCE_EFF);

  // R6: the control byte is otherwise untouched
  a_r6_ctrl_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrCtrl |=> $stable(ctrlReg));

  // R2: nothing decoded reads as all ones
  a_r2_float_high: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RD_NONE) |-> rdData == '1);

endmodule

// File: rtl/ide_regfront.sv
module ide_regfront
  import ide_fe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       strapPriBase,
  input  logic       strapAltBase,
  input  logic       strapSlowBus,
  input  logic       strapDisabled,
  input  logic       strapAltId,
  input  logic [9:0] ioAddr,
  input  logic       ioRdEn,
  input  logic       ioWrEn,
  input  logic [7:0] ioWrData,
  output logic [7:0] ioRdData,
  output logic [7:0] priTiming,
  output logic [7:0] secTiming,
  output logic [7:0] ctrlValue,
  output logic       hdOnly,
  output logic       nonAtapi,
  output logic [1:0] chanSel,
  output logic [2:0] tfReg
);

  feStrobes_t strb;

  ide_fe_decode u_decode (
    .clk          (clk),
    .rstN         (rstN),
    .ioAddr       (ioAddr),
    .ioRdEn       (ioRdEn),
    .ioWrEn       (ioWrEn),
    .strapAltBase (strapAltBase),
    .secDisabled  (ctrlValue[0]),
    .strb         (strb),
    .chanSel      (chanSel),
    .tfReg        (tfReg)
  );

  ide_fe_regs u_regs (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .wrData        (ioWrData),
    .strapPriBase  (strapPriBase),
    .strapAltBase  (strapAltBase),
    .strapSlowBus  (strapSlowBus),
    .strapDisabled (strapDisabled),
    .strapAltId    (strapAltId),
    .priTim        (priTiming),
    .secTim        (secTiming),
    .ctrlReg       (ctrlValue),
    .rdData        (ioRdData)
  );

  assign hdOnly   = ctrlValue[1];
  assign nonAtapi = ctrlValue[7];

  // R10: mode outputs track the stored control byte
  a_r10_mode_bits: assert property (@(posedge clk) disable iff (!rstN)
    hdOnly == ctrlValue[1] && nonAtapi == ctrlValue[7]);

endmodule

// File: tb/tb_ide_regfront.sv
module tb_ide_regfront;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] straps = '0;
  logic [9:0] ioAddr = '0;
  logic       ioRdEn = 1'b0;
  logic       ioWrEn = 1'b0;
  logic [7:0] ioWrData = '0;
  logic [7:0] ioRdData, priTiming, secTiming, ctrlValue;
  logic       hdOnly, nonAtapi;
  logic [1:0] chanSel;
  logic [2:0] tfReg;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #2.5 clk = ~clk;

  ide_regfront dut (
    .clk(clk), .rstN(rstN),
    .strapPriBase(straps[0]), .strapAltBase(straps[1]), .strapSlowBus(straps[2]),
    .strapDisabled(straps[3]), .strapAltId(straps[4]),
    .ioAddr(ioAddr), .ioRdEn(ioRdEn), .ioWrEn(ioWrEn), .ioWrData(ioWrData),
    .ioRdData(ioRdData), .priTiming(priTiming), .secTiming(secTiming),
    .ctrlValue(ctrlValue), .hdOnly(hdOnly), .nonAtapi(nonAtapi),
    .chanSel(chanSel), .tfReg(tfReg)
  );

  // vector: req[30:27] op[26:25] straps[24:20] addr[19:10] data[9:2] sel[1:0]
  // op 0 = write, 1 = read compare, 2 = channel claim compare
  // straps: bit0 priBase, bit1 altBase, bit2 slowBus, bit3 disabled, bit4 altId
  function automatic logic [30:0] mk(int req, int op, logic [4:0] s,
                                     logic [9:0] a, logic [7:0] d, logic [1:0] sel);
    return {4'(req), 2'(op), s, a, d, sel};
  endfunction

  localparam int NV = 33;
  localparam logic [30:0] VEC [NV] = '{
    mk(7, 1, 5'b00000, 10'h030, 8'h00, 2'b00),  // R7 reset primary timing
    mk(7, 1, 5'b00000, 10'h032, 8'h00, 2'b00),  // R7 reset secondary timing
    mk(7, 1, 5'b00000, 10'h033, 8'h5F, 2'b00),  // R7 reset control
    mk(3, 1, 5'b00000, 10'h031, 8'hA0, 2'b00),  // R3 config, all straps low
    mk(4, 0, 5'b00000, 10'h030, 8'h3C, 2'b00),  // R4 write primary
    mk(4, 1, 5'b00000, 10'h030, 8'h3C, 2'b00),
    mk(4, 0, 5'b00000, 10'h032, 8'hE1, 2'b00),  // R4 write secondary
    mk(4, 1, 5'b00000, 10'h032, 8'hE1, 2'b00),
    mk(5, 0, 5'b00000, 10'h031, 8'h77, 2'b00),  // R5 write to config offset
    mk(5, 1, 5'b00000, 10'h030, 8'h3C, 2'b00),
    mk(5, 1, 5'b00000, 10'h032, 8'hE1, 2'b00),
    mk(5, 1, 5'b00000, 10'h033, 8'h5F, 2'b00),
    mk(5, 1, 5'b00000, 10'h031, 8'hA0, 2'b00),
    mk(8, 2, 5'b00000, 10'h1F3, 8'h00, 2'b01),  // R8 primary claimed
    mk(8, 2, 5'b00000, 10'h174, 8'h00, 2'b00),  // R8 secondary off after reset
    mk(6, 0, 5'b00000, 10'h033, 8'h00, 2'b00),  // R6 control write 00
    mk(6, 1, 5'b00000, 10'h033, 8'h5C, 2'b00),
    mk(9, 2, 5'b00000, 10'h174, 8'h00, 2'b10),  // R9 secondary claimed
    mk(9, 2, 5'b00000, 10'h1F7, 8'h00, 2'b01),  // R9 primary still claimed
    mk(12, 2, 5'b00000, 10'h1F8, 8'h00, 2'b00), // R12 edge above primary
    mk(12, 2, 5'b00000, 10'h16F, 8'h00, 2'b00), // R12 edge below secondary
    mk(6, 0, 5'b00000, 10'h033, 8'h83, 2'b00),  // R6 control write 83
    mk(6, 1, 5'b00000, 10'h033, 8'hDF, 2'b00),
    mk(2, 1, 5'b00000, 10'h0B0, 8'hFF, 2'b00),  // R2 other window
    mk(2, 1, 5'b00000, 10'h034, 8'hFF, 2'b00),  // R2 just past window
    mk(1, 1, 5'b00010, 10'h0B3, 8'hDF, 2'b00),  // R1 alternate base
    mk(1, 1, 5'b00010, 10'h031, 8'hFF, 2'b00),  // R1 low window dead
    mk(3, 1, 5'b00010, 10'h0B1, 8'hA2, 2'b00),  // R3 altBase flag
    mk(3, 1, 5'b11101, 10'h031, 8'h5D, 2'b00),  // R3 alt id and flags
    mk(1, 0, 5'b00010, 10'h0B0, 8'h11, 2'b00),  // R1 write at alternate base
    mk(1, 1, 5'b00010, 10'h0B0, 8'h11, 2'b00),
    mk(1, 1, 5'b00010, 10'h030, 8'hFF, 2'b00),
    mk(8, 2, 5'b00000, 10'h174, 8'h00, 2'b00)   // R8 bit 0 set again by 83
  };

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(logic [9:0] a, logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWrEn = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[30:27], i);
      @(negedge clk);
      straps = v[24:20];
      ioAddr = v[19:10];
      case (v[26:25])
        2'd0: begin
          ioWrData = v[9:2]; ioWrEn = 1'b1;
          @(negedge clk);
          ioWrEn = 1'b0;
        end
        2'd1: begin
          ioRdEn = 1'b1; #1;
          check(tag, ioRdData, v[9:2]);
          ioRdEn = 1'b0;
        end
        default: begin
          ioRdEn = 1'b1; #1;
          check(tag, {6'b0, chanSel}, {6'b0, v[1:0]});
          if (v[1:0] != 2'b00) check({tag, " R12 index"}, {5'b0, tfReg}, {5'b0, v[12:10]});
          ioRdEn = 1'b0;
        end
      endcase
    end

    // R10: control is DFh here
    @(negedge clk); straps = '0;
    check("R10 hdOnly set", {7'b0, hdOnly}, 8'h01);
    check("R10 nonAtapi set", {7'b0, nonAtapi}, 8'h01);
    check("R6 ctrlValue port", ctrlValue, 8'hDF);
    wrReg(10'h033, 8'h00);
    check("R10 hdOnly clear", {7'b0, hdOnly}, 8'h00);
    check("R10 nonAtapi clear", {7'b0, nonAtapi}, 8'h00);
    check("R4 priTiming port", priTiming, 8'h11);
    check("R4 secTiming port", secTiming, 8'hE1);

    // R11: no strobe, no claim
    @(negedge clk); ioAddr = 10'h1F2; #1;
    check("R11 idle primary", {6'b0, chanSel}, 8'h00);
    ioAddr = 10'h172; #1;
    check("R11 idle secondary", {6'b0, chanSel}, 8'h00);
    ioWrEn = 1'b1; ioAddr = 10'h176; ioWrData = 8'h00; #1;
    check("R9 write claims secondary", {6'b0, chanSel}, 8'h02);
    check("R12 write index", {5'b0, tfReg}, 8'h06);
    @(negedge clk); ioWrEn = 1'b0;

    // R7: reset in mid-run restores defaults
    @(negedge clk); rstN = 1'b0; #1;
    check("R7 re-reset primary", priTiming, 8'h00);
    check("R7 re-reset secondary", secTiming, 8'h00);
    check("R7 re-reset control", ctrlValue, 8'h5F);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); ioAddr = 10'h033; ioRdEn = 1'b1; #1;
    check("R7 control after release", ioRdData, 8'h5F);
    ioAddr = 10'h171; #1;
    check("R8 secondary off after reset", {6'b0, chanSel}, 8'h00);
    ioRdEn = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule